// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block turns two comparator flags into two active-low reset outputs. One flag reports that the always-on standby 3.3 V rail is above its reset threshold, and the other reports the same for the switched main 3.3 V rail. Each flag crosses into the clock domain through a two-stage synchronizer. A reset output is released only after its flag has stayed valid for a programmable number of clock cycles. With a 32.768 kHz clock the default of 5898 cycles gives about 180 ms.

The two resets are chained. The main reset counts only while its own rail is valid and the standby reset is already released. It therefore releases a full delay after whichever of those two events comes later. A drop on either rail reasserts the matching reset and clears its counter. A standby drop also pulls the main reset back down.

The main reset line is a wired-AND pin. The block drives it low through `main_rst_no` and senses its level on `rst_pin_i`. Whenever the synchronized pin level has been low for a minimum number of consecutive cycles, the block raises `reg_init_o`. This holds the register bank at its default values. An external pull-down therefore works as a reset input, and short glitches on the pin are filtered out.

Top module: `dual_rail_reset_seq`

## Requirements
- R1: While `rst_ni` is low, `stby_rst_no`, `main_rst_no` and `reg_init_o` are all 0. On both reset outputs, 0 means reset asserted and 1 means released.
- R2: When `stby_ok_i` rises and stays high, `stby_rst_no` goes to 1 exactly DELAY_CYC+2 cycles later. This is two synchronizer cycles plus DELAY_CYC counting cycles.
- R3: When the standby reset is released early enough, `main_rst_no` goes to 1 exactly DELAY_CYC+2 cycles after `main_ok_i` rises.
- R4: When `main_ok_i` is already valid, `main_rst_no` goes to 1 exactly DELAY_CYC cycles after `stby_rst_no` goes to 1.
- R5: A low on `stby_ok_i` forces `stby_rst_no` to 0 three cycles later and `main_rst_no` to 0 one cycle after that. After a dip of any length, both resets need their full delays again.
- R6: A low on `main_ok_i` forces `main_rst_no` to 0 three cycles later and leaves `stby_rst_no` unchanged. After the rail returns, the full DELAY_CYC+2 delay applies again.
- R7: `reg_init_o` goes to 1 exactly MIN_LOW+2 cycles after `rst_pin_i` falls, provided the pin stays low for at least MIN_LOW cycles. A low pulse shorter than MIN_LOW cycles leaves `reg_init_o` at 0.
- R8: `reg_init_o` returns to 0 three cycles after `rst_pin_i` returns high.
- R9: A low on `rst_pin_i` that the block itself did not drive has no effect on `stby_rst_no` or `main_rst_no`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock that times the delays |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| stby_ok_i | input | 1 | Standby rail above threshold (asynchronous) |
| main_ok_i | input | 1 | Main rail above threshold (asynchronous) |
| rst_pin_i | input | 1 | Sensed level of the wired-AND main reset pin |
| stby_rst_no | output | 1 | Standby reset, active low |
| main_rst_no | output | 1 | Main reset pin pull-down, active low |
| reg_init_o | output | 1 | Holds the register bank at defaults while high |

## Verification
The assertions assume that the rail flags and the pin level are sampled only after the two-stage synchronizers. They also assume that the sensed pin level is the wired-AND of the block's own drive and any external pull, and that the delay windows are checked with saturating run counters rather than long histories. The bench drives every input on the falling clock edge, so that each change lands in a known synchronizer cycle. It models the pin as the AND of `main_rst_no` and an external pull. Before each scenario it holds both rails low for longer than one delay, so that every sweep starts from the fully asserted state.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/drs_delay.sv
module drs_delay
  import drs_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 5898
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rel_o
);
  localparam int unsigned CW = cnt_w(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  // any low sample clears progress; release after DELAY_CYC high samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rel_o = rel_q;
endmodule

// File: rtl/drs_pin_filter.sv
module drs_pin_filter
  import drs_pkg::*;
#(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic init_o
);
  localparam int unsigned CW = cnt_w(MIN_LOW);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_q <= '0;
    else if (pin_s_i)     low_q <= '0;
    else if (low_q != LIM) low_q <= low_q + 1'b1;
  end

  assign init_o = (low_q == LIM);
endmodule

// File: rtl/dual_rail_reset_seq.sv
module dual_rail_reset_seq
  import drs_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 5898,
  parameter int unsigned MIN_LOW   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_ok_i,
  input  logic main_ok_i,
  input  logic rst_pin_i,
  output logic stby_rst_no,
  output logic main_rst_no,
  output logic reg_init_o
);
  logic [1:0] rail_s;
  logic       stby_ok_s;
  logic       main_ok_s;
  logic       pin_s;
  logic       stby_rel;
  logic       main_rel;

  drs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_rail_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({main_ok_i, stby_ok_i}),
    .q_o   (rail_s)
  );

  assign stby_ok_s = rail_s[0];
  assign main_ok_s = rail_s[1];

  // pin idles high so a reset of the sequencer alone does not clear registers
  drs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_i),
    .q_o   (pin_s)
  );

  drs_delay #(.DELAY_CYC(DELAY_CYC)) u_stby_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (stby_ok_s),
    .rel_o (stby_rel)
  );

  // main counts only once standby is out of reset
  drs_delay #(.DELAY_CYC(DELAY_CYC)) u_main_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (main_ok_s & stby_rel),
    .rel_o (main_rel)
  );

  drs_pin_filter #(.MIN_LOW(MIN_LOW)) u_pin_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .init_o (reg_init_o)
  );

  assign stby_rst_no = stby_rel;
  assign main_rst_no = main_rel;
endmodule

// File: rtl/dual_rail_reset_seq_chk.sv
module dual_rail_reset_seq_chk
  import drs_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 5898,
  parameter int unsigned MIN_LOW   = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stby_ok_i,
  input logic stby_ok_s,
  input logic main_ok_s,
  input logic pin_s,
  input logic stby_rst_no,
  input logic main_rst_no,
  input logic reg_init_o
);
  localparam int unsigned DW = cnt_w(DELAY_CYC);
  localparam int unsigned LW = cnt_w(MIN_LOW);
  localparam logic [DW-1:0] DSAT = DW'(DELAY_CYC);
  localparam logic [LW-1:0] LSAT = LW'(MIN_LOW);

  logic [DW-1:0] srun_q, mrun_q;
  logic [LW-1:0] lrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srun_q <= '0;
      mrun_q <= '0;
      lrun_q <= '0;
    end else begin
      if (!stby_ok_s)          srun_q <= '0;
      else if (srun_q != DSAT) srun_q <= srun_q + 1'b1;
      if (!(main_ok_s && stby_rst_no)) mrun_q <= '0;
      else if (mrun_q != DSAT)         mrun_q <= mrun_q + 1'b1;
      if (pin_s)               lrun_q <= '0;
      else if (lrun_q != LSAT) lrun_q <= lrun_q + 1'b1;
    end
  end

  AST_STBY_FULL_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stby_rst_no) |-> srun_q == DSAT); // R2

  AST_MAIN_FULL_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_rst_no) |-> mrun_q == DSAT); // R4

  AST_MAIN_FOLLOWS_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_rst_no |=> !main_rst_no); // R5

  AST_STBY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_ok_i && !$past(stby_ok_i) && !$past(stby_ok_i, 2)) |=> !stby_rst_no); // R5

  AST_MAIN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_ok_s |=> !main_rst_no); // R6

  AST_INIT_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_init_o) |-> lrun_q == LSAT); // R7

  AST_INIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_s |=> !reg_init_o); // R8
endmodule

bind dual_rail_reset_seq dual_rail_reset_seq_chk #(
  .DELAY_CYC(DELAY_CYC),
  .MIN_LOW  (MIN_LOW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stby_ok_i  (stby_ok_i),
  .stby_ok_s  (stby_ok_s),
  .main_ok_s  (main_ok_s),
  .pin_s      (pin_s),
  .stby_rst_no(stby_rst_no),
  .main_rst_no(main_rst_no),
  .reg_init_o (reg_init_o)
);

// File: tb/dual_rail_reset_seq_tb.sv
`timescale 1ns/1ps
module dual_rail_reset_seq_tb;
  localparam int D  = 8;
  localparam int ML = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_ok = 1'b0, main_ok = 1'b0, ext_n = 1'b1;
  logic stby_rst_n, main_rst_n, reg_init;
  logic pin;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pin = main_rst_n & ext_n;

  dual_rail_reset_seq #(.DELAY_CYC(D), .MIN_LOW(ML)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .stby_ok_i  (stby_ok),
    .main_ok_i  (main_ok),
    .rst_pin_i  (pin),
    .stby_rst_no(stby_rst_n),
    .main_rst_no(main_rst_n),
    .reg_init_o (reg_init)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic settle_low();
    stby_ok = 1'b0; main_ok = 1'b0; ext_n = 1'b1;
    repeat (D + 8) @(negedge clk);
  endtask

  // rails rise at cycle s0 / m0; sample at negedge n reflects edges 0..n-1
  task automatic run_case(int s0, int m0);
    int s_rel, m_rel, nmax;
    string mtag;
    s_rel = s0 + D + 1;
    m_rel = (m0 + D + 1 > s_rel + D) ? m0 + D + 1 : s_rel + D;
    mtag  = (m0 + D + 1 > s_rel + D) ? "R3 own rail" : "R4 after standby";
    nmax  = m_rel + 4;
    settle_low();
    for (int n = 0; n <= nmax; n++) begin
      @(negedge clk);
      check("R2 standby release", int'(stby_rst_n), int'(n >= s_rel + 1));
      check(mtag, int'(main_rst_n), int'(n >= m_rel + 1));
      stby_ok = (n >= s0);
      main_ok = (n >= m0);
    end
  endtask

  task automatic bring_up();
    run_case(0, 0);
  endtask

  // standby dip of width w starting at cycle p
  task automatic run_stby_dip(int w);
    int p = 2;
    bring_up();
    for (int n = 0; n <= p + w + 2 * D + 6; n++) begin
      @(negedge clk);
      check("R5 standby drop", int'(stby_rst_n), int'(!(n >= p + 3 && n < p + w + D + 2)));
      check("R5 main follows", int'(main_rst_n), int'(!(n >= p + 4 && n < p + w + 2 * D + 2)));
      stby_ok = !(n >= p && n < p + w);
    end
  endtask

  task automatic run_main_dip(int w);
    int p = 2;
    bring_up();
    for (int n = 0; n <= p + w + D + 6; n++) begin
      @(negedge clk);
      check("R6 standby kept", int'(stby_rst_n), 1);
      check("R6 main drop", int'(main_rst_n), int'(!(n >= p + 3 && n < p + w + D + 2)));
      main_ok = !(n >= p && n < p + w);
    end
  endtask

  // external pull of width w starting at cycle p
  task automatic run_pull(int w);
    int p = 2;
    bring_up();
    repeat (4) @(negedge clk);
    for (int n = 0; n <= p + w + 6; n++) begin
      @(negedge clk);
      if (w >= ML)
        check(n > p + w + 2 ? "R8 init release" : "R7 init assert", int'(reg_init),
              int'(n >= p + ML + 2 && n <= p + w + 2));
      else
        check("R7 short pulse ignored", int'(reg_init), 0);
      check("R9 standby unaffected", int'(stby_rst_n), 1);
      check("R9 main unaffected", int'(main_rst_n), 1);
      ext_n = !(n >= p && n < p + w);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    stby_ok = 1'b1; main_ok = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset standby low", int'(stby_rst_n), 0);
    check("R1 reset main low", int'(main_rst_n), 0);
    check("R1 reset init low", int'(reg_init), 0);
    stby_ok = 1'b0; main_ok = 1'b0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // own drive holds the pin low, so the register bank stays at defaults
    check("R7 self drive holds defaults", int'(reg_init), 1);

    for (int m0 = 0; m0 <= 3 + D + 6; m0++) run_case(3, m0);
    for (int w = 1; w <= 3; w++) run_stby_dip(w);
    for (int w = 1; w <= 3; w++) run_main_dip(w);
    for (int w = 0; w <= 5; w++) run_pull(w);
    finish_run();
  end
endmodule